// File: doc/BRIEF.md
# SPI Flash Byte-Transfer Engine

This block is the serial physical layer of a single-lane SPI flash reader. A controller hands it one operation at a time: a byte count from 1 to 9 and a 72-bit word holding the command, address and dummy bytes, left-aligned. The engine clocks those bytes out most-significant bit first on the data-out line and gathers the data-in line into a 32-bit read word. It does not divide the clock itself. An external divider supplies a one-cycle strobe, and every strobe seen during an operation produces one serial clock edge. Each half-period of the serial clock is therefore one strobe interval, and the clock is symmetric.

Chip-select can stay asserted across several operations, so that a burst read can continue the same flash access. It is released only when an operation that carried the final flag has completed. A separate select-enable flag, sampled with each request, can keep the select line high for that operation. This lets the controller send clocks, such as a wake-up preamble, while the flash is deselected. The sequencer has three states. ST_IDLE moves to ST_LEAD when a legal request arrives. ST_LEAD moves to ST_TRAIL on a strobe, which produces the leading edge. ST_TRAIL moves back to ST_LEAD on a strobe, which produces the trailing edge, or to ST_IDLE if that trailing edge ended the last bit.

Top module: `spi_flash_phy`

## Requirements
- R1: A request is accepted only in idle, with `op_start` high and `op_nbytes` in 1..9. `op_busy` rises in the cycle after acceptance. It falls in the cycle after the strobe that makes the final trailing edge, which is the 16·N-th strobe for N bytes.
- R2: A request whose count is 0 or 10..15 is ignored. `op_busy` stays low and `cs_n` does not change.
- R3: `op_start` is ignored while `op_busy` is high. No second operation follows the current one unless a new request is made in idle.
- R4: `mosi` carries bits 71 downward of `op_wdata`, using only the top N bytes. With `cpha`=0 the first bit appears in the cycle after acceptance and each later bit changes on a trailing edge. With `cpha`=1 each bit changes on a leading edge. `mosi` is 0 whenever the engine is idle.
- R5: In idle, `sck` equals `cpol`. While busy, each strobe inverts `sck`, and without a strobe `sck` holds its value. Each bit uses one leading and one trailing edge.
- R6: `miso` is sampled on leading edges when `cpha`=0 and on trailing edges when `cpha`=1. Each sample shifts into bit 0 of `op_rdata`, so bit 31 holds the oldest of the last 32 samples. `op_rdata` is cleared when a request is accepted and is kept after the operation ends.
- R7: In the cycle after acceptance, `cs_n` becomes the inverse of `op_sel_en` as sampled with the request. With `op_sel_en`=0 the select line stays high for the whole operation, while the clock and data still run.
- R8: `op_final` is sampled with the request. If it was 1, `cs_n` goes high in the same cycle that `op_busy` falls. If it was 0, `cs_n` keeps its level into idle and until the next accepted request.
- R9: A synchronous active-high `rst` brings the engine to idle: `op_busy`=0, `cs_n`=1, `mosi`=0, `op_rdata`=0 and `sck`=`cpol`. This holds also when the reset arrives in the middle of an operation.
- R10: Strobes on `tick` while the engine is idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Single-cycle strobe from the external clock divider; one serial clock edge per strobe |
| cpol | input | 1 | Serial clock idle level; must be steady while busy |
| cpha | input | 1 | Clock phase: 0 samples on leading edges, 1 on trailing edges; must be steady while busy |
| op_start | input | 1 | Request strobe |
| op_nbytes | input | CNT_W (4) | Number of bytes to send, legal range 1..MAX_BYTES |
| op_wdata | input | 8·MAX_BYTES (72) | Left-aligned bytes to send |
| op_final | input | 1 | Release chip-select when this operation ends |
| op_sel_en | input | 1 | Allow chip-select to assert for this operation |
| op_busy | output | 1 | Operation in progress |
| op_rdata | output | RD_W (32) | Last received bits, newest in bit 0 |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip-select, active low |

## Verification
Every output of this engine is registered, so each result appears in the cycle after the clock edge that caused it. `op_busy`, `cs_n` and the first `mosi` bit (for `cpha`=0) follow the accepting edge by one cycle. Every `sck`, `mosi` and `op_rdata` change follows the edge that carried a strobe by one cycle. The release of `op_busy` and `cs_n` follows the last trailing strobe by one cycle. The bench changes inputs just after the rising edge. A behavioural model advances on that same rising edge from the same inputs, and the design is compared against it at the falling edge of every cycle, so each check lands exactly in the cycle its result is due.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } sfx_state_e;
endpackage

// File: rtl/sfx_bit_ctrl.sv
module sfx_bit_ctrl
    import sfx_pkg::*;
#(
    parameter int MAX_BYTES = 9,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] nbytes,
    output logic             accept,
    output logic             lead_evt,
    output logic             trail_evt,
    output logic             done,
    output logic             busy,
    output logic             sck_act
);
    localparam int BIT_W = $clog2(MAX_BYTES * 8 + 1);

    sfx_state_e       state_q, state_d;
    logic [BIT_W-1:0] bits_left;
    logic             legal;

    // event decode
    always_comb begin
        legal     = (nbytes != '0) && (int'(nbytes) <= MAX_BYTES);
        accept    = (state_q == ST_IDLE) && start && legal;
        lead_evt  = (state_q == ST_LEAD) && tick;
        trail_evt = (state_q == ST_TRAIL) && tick;
        done      = trail_evt && (bits_left == BIT_W'(1));
        busy      = (state_q != ST_IDLE);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_LEAD;
            ST_LEAD:  if (tick)   state_d = ST_TRAIL;
            ST_TRAIL: if (tick)   state_d = (bits_left == BIT_W'(1)) ? ST_IDLE : ST_LEAD;
            default:              state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // bit counter and clock level
    always_ff @(posedge clk) begin
        if (rst) begin
            bits_left <= '0;
            sck_act   <= 1'b0;
        end else begin
            if (accept)         bits_left <= BIT_W'(nbytes) << 3;
            else if (trail_evt) bits_left <= bits_left - BIT_W'(1);
            if (lead_evt)       sck_act <= 1'b1;
            else if (trail_evt) sck_act <= 1'b0;
        end
    end
endmodule

// File: rtl/sfx_shift_out.sv
module sfx_shift_out #(
    parameter int WR_W = 72
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cpha,
    input  logic            accept,
    input  logic            lead_evt,
    input  logic            trail_evt,
    input  logic            done,
    input  logic [WR_W-1:0] wdata,
    output logic            mosi
);
    logic [WR_W-1:0] tx_q;
    logic            shift_evt;

    always_comb shift_evt = cpha ? lead_evt : trail_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            mosi <= 1'b0;
        end else if (accept) begin
            // phase 0 presents the first bit before the leading edge
            tx_q <= cpha ? wdata : (wdata << 1);
            mosi <= cpha ? 1'b0 : wdata[WR_W-1];
        end else if (done) begin
            mosi <= 1'b0;
        end else if (shift_evt) begin
            mosi <= tx_q[WR_W-1];
            tx_q <= tx_q << 1;
        end
    end
endmodule

// File: rtl/sfx_shift_in.sv
module sfx_shift_in #(
    parameter int RD_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cpha,
    input  logic            accept,
    input  logic            lead_evt,
    input  logic            trail_evt,
    input  logic            miso,
    output logic [RD_W-1:0] rdata
);
    logic sample_evt;

    always_comb sample_evt = cpha ? trail_evt : lead_evt;

    always_ff @(posedge clk) begin
        if (rst || accept) rdata <= '0;
        else if (sample_evt) rdata <= {rdata[RD_W-2:0], miso};
    end
endmodule

// File: rtl/spi_flash_phy.sv
module spi_flash_phy #(
    parameter int MAX_BYTES = 9,
    parameter int CNT_W     = 4,
    parameter int RD_W      = 32,
    localparam int WR_W     = MAX_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             op_start,
    input  logic [CNT_W-1:0] op_nbytes,
    input  logic [WR_W-1:0]  op_wdata,
    input  logic             op_final,
    input  logic             op_sel_en,
    output logic             op_busy,
    output logic [RD_W-1:0]  op_rdata,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    logic accept, lead_evt, trail_evt, done, sck_act;
    logic final_q, cs_q;

    sfx_bit_ctrl #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .start(op_start), .nbytes(op_nbytes),
        .accept(accept), .lead_evt(lead_evt), .trail_evt(trail_evt),
        .done(done), .busy(op_busy), .sck_act(sck_act)
    );

    sfx_shift_out #(.WR_W(WR_W)) u_tx (
        .clk(clk), .rst(rst), .cpha(cpha), .accept(accept),
        .lead_evt(lead_evt), .trail_evt(trail_evt), .done(done),
        .wdata(op_wdata), .mosi(mosi)
    );

    sfx_shift_in #(.RD_W(RD_W)) u_rx (
        .clk(clk), .rst(rst), .cpha(cpha), .accept(accept),
        .lead_evt(lead_evt), .trail_evt(trail_evt), .miso(miso), .rdata(op_rdata)
    );

    // chip-select: set per request, released only by a final operation
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b1;
            final_q <= 1'b0;
        end else if (accept) begin
            cs_q    <= ~op_sel_en;
            final_q <= op_final;
        end else if (done && final_q) begin
            cs_q    <= 1'b1;
        end
    end

    always_comb begin
        cs_n = cs_q;
        sck  = sck_act ^ cpol;
    end
endmodule

// File: rtl/spi_flash_phy_chk.sv
module spi_flash_phy_chk #(
    parameter int MAX_BYTES = 9,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             cpol,
    input logic             op_start,
    input logic [CNT_W-1:0] op_nbytes,
    input logic             op_sel_en,
    input logic             op_busy,
    input logic             sck,
    input logic             mosi,
    input logic             cs_n
);
    assert_idle_mosi_R4: assert property (@(posedge clk) disable iff (rst)
        !op_busy |-> !mosi);

    assert_idle_sck_R5: assert property (@(posedge clk) disable iff (rst)
        !op_busy |-> (sck == cpol));

    assert_sck_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (op_busy && !tick) |=> $stable(sck));

    assert_sel_follow_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(op_busy) |-> (cs_n == !$past(op_sel_en)));

    assert_bad_count_R2: assert property (@(posedge clk) disable iff (rst)
        (!op_busy && op_start && ((op_nbytes == '0) || (int'(op_nbytes) > MAX_BYTES)))
        |=> !op_busy);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!op_busy && !op_start) |=> !op_busy);
endmodule

bind spi_flash_phy spi_flash_phy_chk #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .cpol(cpol), .op_start(op_start),
    .op_nbytes(op_nbytes), .op_sel_en(op_sel_en), .op_busy(op_busy),
    .sck(sck), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/spi_flash_phy_test.sv
`timescale 1ns/1ps
module spi_flash_phy_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, cpol = 1'b0, cpha = 1'b0;
    logic        op_start = 1'b0, op_final = 1'b0, op_sel_en = 1'b0;
    logic [3:0]  op_nbytes = 4'd0;
    logic [71:0] op_wdata = '0;
    logic        miso = 1'b0;
    logic        op_busy, sck, mosi, cs_n;
    logic [31:0] op_rdata;

    int n_chk = 0, n_fail = 0, cycles = 0;
    int tick_mode = 0;
    bit started = 0;

    always #2 clk = ~clk;

    spi_flash_phy uut (
        .clk(clk), .rst(rst), .tick(tick), .cpol(cpol), .cpha(cpha),
        .op_start(op_start), .op_nbytes(op_nbytes), .op_wdata(op_wdata),
        .op_final(op_final), .op_sel_en(op_sel_en), .op_busy(op_busy),
        .op_rdata(op_rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_busy = 0, m_cs_n = 1, m_act = 0, m_mosi = 0, m_last = 0;
    logic [31:0] m_rx = '0;
    int          m_half = 0;
    bit          m_q[$];

    always @(posedge clk) begin
        cycles++;
        started = 1;
        if (rst) begin
            m_busy = 0; m_cs_n = 1; m_act = 0; m_mosi = 0; m_rx = '0; m_q.delete();
        end else if (!m_busy) begin
            if (op_start && op_nbytes >= 1 && op_nbytes <= 9) begin
                m_busy = 1; m_cs_n = !op_sel_en; m_last = op_final; m_rx = '0;
                m_q.delete();
                for (int i = 0; i < op_nbytes * 8; i++) m_q.push_back(op_wdata[71-i]);
                m_half = op_nbytes * 16;
                m_mosi = cpha ? 1'b0 : m_q.pop_front();
            end
        end else if (tick) begin
            if (m_half % 2 == 0) begin
                m_act = 1;
                if (!cpha) m_rx = {m_rx[30:0], miso};
                else       m_mosi = m_q.pop_front();
            end else begin
                m_act = 0;
                if (!cpha) m_mosi = (m_q.size() == 0) ? 1'b0 : m_q.pop_front();
                else       m_rx = {m_rx[30:0], miso};
            end
            m_half--;
            if (m_half == 0) begin
                m_busy = 0; m_mosi = 0;
                if (m_last) m_cs_n = 1;
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            check(op_busy === m_busy, "R1", "busy", 32'(op_busy), 32'(m_busy));
            check(mosi === m_mosi, "R4", "mosi", 32'(mosi), 32'(m_mosi));
            check(sck === (m_act ^ cpol), "R5", "sck", 32'(sck), 32'(m_act ^ cpol));
            check(op_rdata === m_rx, "R6", "rdata", op_rdata, m_rx);
            check(cs_n === m_cs_n, "R7/R8", "cs_n", 32'(cs_n), 32'(m_cs_n));
        end
    end

    // strobe and data-in drivers
    initial begin
        int div = 0;
        logic [15:0] lf = 16'hACE1;
        forever begin
            @(posedge clk); #1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            miso = lf[3] ^ lf[9];
            div = (div + 1) % 3;
            case (tick_mode)
                0: tick = 1'b1;
                1: tick = (div == 0);
                default: tick = lf[0] & lf[5];
            endcase
        end
    end

    // watchdog
    initial begin
        wait (cycles > 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic wait_idle();
        int g = 0;
        @(negedge clk);
        while (op_busy && g < 5000) begin @(negedge clk); g++; end
    endtask

    task automatic run_op(input int n, input logic [71:0] w, input bit fin, input bit sel);
        @(posedge clk); #1;
        op_start = 1; op_nbytes = 4'(n); op_wdata = w; op_final = fin; op_sel_en = sel;
        @(posedge clk); #1;
        op_start = 0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R9: reset state
        check(!op_busy && cs_n && !mosi && op_rdata == 0 && sck == cpol, "R9",
              "reset state", {27'b0, op_busy, cs_n, mosi, sck, 1'b0}, 32'h8);

        // R10: strobes in idle
        repeat (6) @(negedge clk);
        check(!op_busy && sck == cpol, "R10", "idle strobes", 32'(op_busy), 32'd0);

        // R2: illegal counts
        @(posedge clk); #1 op_start = 1; op_nbytes = 4'd0; op_sel_en = 1;
        @(posedge clk); #1 op_nbytes = 4'd12;
        @(posedge clk); #1 op_start = 0;
        @(negedge clk);
        check(!op_busy && cs_n, "R2", "illegal count", {30'b0, op_busy, cs_n}, 32'd1);

        // all four modes, several counts and strobe patterns
        for (int md = 0; md < 4; md++) begin
            @(posedge clk); #1 cpol = md[1]; cpha = md[0];
            tick_mode = md % 3;
            run_op(1, 72'hA5_0000_0000_0000_0000, 1, 1);
            run_op(4, 72'h0B_1234_56C3_0000_0000, 1, 1);
            run_op(9, 72'hF0_0F55_AA33_CC96_69E1, 1, 1);
        end

        // R8: burst with chip-select held
        @(posedge clk); #1 cpol = 0; cpha = 0; tick_mode = 1;
        run_op(4, 72'h03_0012_3400_0000_0000, 0, 1);
        repeat (3) @(negedge clk);
        check(!cs_n, "R8", "select held", 32'(cs_n), 32'd0);
        run_op(4, 72'hFF_FFFF_FF00_0000_0000, 0, 1);
        run_op(2, 72'h5A5A_0000_0000_0000_00, 1, 1);
        @(negedge clk);
        check(cs_n, "R8", "select released", 32'(cs_n), 32'd1);

        // R7: dummy clocks with select disabled
        tick_mode = 2;
        run_op(8, 72'hFFFF_FFFF_FFFF_FFFF_00, 1, 0);
        check(cs_n, "R7", "deselected run", 32'(cs_n), 32'd1);

        // R3: request while busy is ignored
        @(posedge clk); #1 tick_mode = 1; cpha = 1;
        op_start = 1; op_nbytes = 2; op_wdata = 72'hC3_3C00_0000_0000_0000; op_final = 1; op_sel_en = 1;
        @(posedge clk); #1 op_start = 0;
        repeat (5) @(posedge clk);
        #1 op_start = 1; op_nbytes = 9; op_wdata = '1;
        @(posedge clk); #1 op_start = 0;
        wait_idle();
        repeat (3) @(negedge clk);
        check(!op_busy, "R3", "no second op", 32'(op_busy), 32'd0);

        // R9: reset during an operation
        @(posedge clk); #1 tick_mode = 0;
        op_start = 1; op_nbytes = 9; op_wdata = 72'h81_8181_8181_8181_8181; op_final = 0;
        @(posedge clk); #1 op_start = 0;
        repeat (7) @(posedge clk);
        #1 rst = 1;
        @(posedge clk); #1 rst = 0;
        @(negedge clk);
        check(!op_busy && cs_n && !mosi && op_rdata == 0, "R9", "mid-op reset",
              {29'b0, op_busy, cs_n, mosi}, 32'd2);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule